// File: doc/BRIEF.md
# Bridge Control Register File

This block is a bank of 28 32-bit control words for a host bridge, reached over a simple bus that carries a byte address, a write enable with write data, and a read strobe. Most words are plain storage that software writes and reads back. A few words behave differently.

The interrupt enable word cannot be written directly. Software sets enable bits through one alias word and clears them through a second alias word, and each alias also keeps the last value written to it. The enable word and the interrupt status word are read-only. The status word reads back the external interrupt status vector as it stands when the read is sampled.

The general configuration word carries a soft-reset control bit. When a write moves that bit from 0 to 1, the block emits a one-cycle reset-request pulse that the system reset logic consumes. Read data is registered. It appears the cycle after the read strobe and holds until the next strobe.

Top module: `bcr_regfile`

## Requirements
- R1: After synchronous reset, reads return these values: 0x00000C40 at byte offset 0x00, 0x00001384 at 0x04, 0x2BFF8010 at 0x08, 0x255E0091 at 0x0C, 0x00006140 at 0x10, 0x000001FF at 0x1C and at 0x20, 0x00000008 at 0x68, 0x10000000 at 0x6C, and zero at every other offset from 0x00 to 0x6C. The word at 0x3C is the exception: it returns the interrupt status input.
- R2: A register is selected by bits [7:2] of the byte address. A write to any offset from 0x00 to 0x6C, other than 0x38 and 0x3C, stores the write data. `bus_rdata` takes the addressed value on the clock edge where `bus_rd` is high and holds it while `bus_rd` is low.
- R3: A write to 0x30 stores the data at 0x30 and sets every enable bit (readable at 0x38) where the data has a one. Other enable bits are left unchanged.
- R4: A write to 0x34 stores the data at 0x34 and clears every enable bit where the data has a one. Other enable bits are left unchanged.
- R5: Writes to 0x38 (enable) and 0x3C (interrupt status) change nothing. A read of 0x3C returns `irq_status` as sampled on the read edge.
- R6: Writes whose word index is 28 or above (byte offset 0x70 and up) change no register. Reads of those offsets return zero.
- R7: A write to 0x04 that changes bit 2 from 0 to 1 stores the new value and raises `reset_req` in the following cycle.
- R8: `reset_req` is high for exactly one cycle. A write to 0x04 raises no request when bit 2 was already 1 or stays 0.
- R9: When a read and a write address the same register in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address; bits [7:2] select the word |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| irq_status | input | 32 | External interrupt status vector |
| bus_rdata | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle soft-reset request |

## Verification
Several properties are checked on every cycle:
- the enable word responds correctly to the set and clear aliases and otherwise stays stable;
- `reset_req` never lasts more than one cycle and fires exactly when the stored soft-reset bit rises;
- reads of addresses past the bank return zero.

The bench's scenarios and reference model are needed for the rest. These are the reset values of each word, storage of plain words, the write-then-read ordering within one cycle, the sampling of `irq_status` on reads, and proof that writes to read-only or out-of-range addresses leave every word untouched.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    localparam int BCR_DW    = 32;
    localparam int BCR_AW    = 8;
    localparam int BCR_NREGS = 28;

    // word indices whose behaviour differs from plain storage
    localparam int IDX_GENCFG = 1;
    localparam int IDX_EN_SET = 12;
    localparam int IDX_EN_CLR = 13;
    localparam int IDX_EN     = 14;
    localparam int IDX_IRQ    = 15;
    localparam int SOFT_RST_BIT = 2;

    typedef enum logic [2:0] {
        ACC_PLAIN  = 3'd0,
        ACC_GENCFG = 3'd1,
        ACC_SET    = 3'd2,
        ACC_CLR    = 3'd3,
        ACC_EN     = 3'd4,
        ACC_IRQ    = 3'd5
    } acc_kind_e;

    function automatic acc_kind_e kind_of(input int idx);
        case (idx)
            IDX_GENCFG: return ACC_GENCFG;
            IDX_EN_SET: return ACC_SET;
            IDX_EN_CLR: return ACC_CLR;
            IDX_EN:     return ACC_EN;
            IDX_IRQ:    return ACC_IRQ;
            default:    return ACC_PLAIN;
        endcase
    endfunction

    function automatic logic [BCR_DW-1:0] reset_value(input int idx);
        case (idx)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7, 8:    return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
    import bcr_pkg::*;
#(
    parameter int ADDR_W   = BCR_AW,
    parameter int NUM_REGS = BCR_NREGS,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              valid,
    output acc_kind_e         kind
);
    always_comb begin
        idx   = addr[ADDR_W-1:2];
        valid = (int'(idx) < NUM_REGS);
        kind  = kind_of(int'(idx));
    end
endmodule

// File: rtl/bcr_int_enable.sv
module bcr_int_enable #(
    parameter int DATA_W = bcr_pkg::BCR_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q
);
    always_ff @(posedge clk) begin
        if (rst)         en_q <= '0;
        else if (set_we) en_q <= en_q | wdata;
        else if (clr_we) en_q <= en_q & ~wdata;
    end

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((en_q & $past(wdata)) == $past(wdata)));
    // R4
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((en_q & $past(wdata)) == '0));
    // R5
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(en_q));
endmodule

// File: rtl/bcr_reset_pulse.sv
module bcr_reset_pulse (
    input  logic clk,
    input  logic rst,
    input  logic gen_we,
    input  logic old_bit,
    input  logic new_bit,
    output logic pulse_q
);
    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= gen_we && !old_bit && new_bit;
    end

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);
endmodule

// File: rtl/bcr_regfile.sv
module bcr_regfile
    import bcr_pkg::*;
#(
    parameter int DATA_W   = BCR_DW,
    parameter int ADDR_W   = BCR_AW,
    parameter int NUM_REGS = BCR_NREGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] irq_status,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] acc_idx;
    logic             acc_valid;
    acc_kind_e        acc_kind;

    bcr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .addr (bus_addr),
        .idx  (acc_idx),
        .valid(acc_valid),
        .kind (acc_kind)
    );

    logic wr_hit;
    assign wr_hit = bus_wr && acc_valid;

    logic [NUM_REGS-1:0][DATA_W-1:0] word_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        if (g == IDX_EN || g == IDX_IRQ) begin : g_virtual
            assign word_q[g] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] r_q;
            always_ff @(posedge clk) begin
                if (rst)
                    r_q <= DATA_W'(reset_value(g));
                else if (wr_hit && int'(acc_idx) == g)
                    r_q <= bus_wdata;
            end
            assign word_q[g] = r_q;
        end
    end

    logic [DATA_W-1:0] en_q;

    bcr_int_enable #(.DATA_W(DATA_W)) u_en (
        .clk   (clk),
        .rst   (rst),
        .set_we(wr_hit && acc_kind == ACC_SET),
        .clr_we(wr_hit && acc_kind == ACC_CLR),
        .wdata (bus_wdata),
        .en_q  (en_q)
    );

    bcr_reset_pulse u_rp (
        .clk    (clk),
        .rst    (rst),
        .gen_we (wr_hit && acc_kind == ACC_GENCFG),
        .old_bit(word_q[IDX_GENCFG][SOFT_RST_BIT]),
        .new_bit(bus_wdata[SOFT_RST_BIT]),
        .pulse_q(reset_req)
    );

    logic [DATA_W-1:0] rd_next;
    always_comb begin
        rd_next = '0;
        if (acc_valid) begin
            case (acc_kind)
                ACC_EN:  rd_next = en_q;
                ACC_IRQ: rd_next = irq_status;
                default: rd_next = word_q[acc_idx];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    // R7
    soft_rst_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(word_q[IDX_GENCFG][SOFT_RST_BIT]) |-> reset_req);
    // R7
    soft_rst_cause_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $rose(word_q[IDX_GENCFG][SOFT_RST_BIT]));
    // R6
    out_of_range_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !acc_valid) |=> (bus_rdata == '0));
endmodule

// File: tb/sim_bcr_regfile.sv
module sim_bcr_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] irq_status = '0;
    logic [31:0] bus_rdata;
    logic        reset_req;

    always #5 clk = ~clk;

    bcr_regfile u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .irq_status(irq_status),
        .bus_rdata(bus_rdata), .reset_req(reset_req)
    );

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    bit    started = 0;
    string cur_tag = "R1";
    string exp_tag = "R1";

    // behavioural reference model
    logic [31:0] m_regs [28];
    logic [31:0] m_en;
    logic [31:0] exp_rd;
    logic        exp_req;

    function automatic logic [31:0] init_val(input int i);
        case (i)
            0: return 32'hC40;        1: return 32'h1384;
            2: return 32'h2BFF8010;   3: return 32'h255E0091;
            4: return 32'h6140;       7: return 32'h1FF;
            8: return 32'h1FF;        26: return 32'h8;
            27: return 32'h10000000;  default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        int i;
        started = 1;
        exp_tag = cur_tag;
        i = int'(bus_addr[7:2]);
        if (rst) begin
            for (int k = 0; k < 28; k++) m_regs[k] = init_val(k);
            m_en = 0; exp_rd = 0; exp_req = 0;
        end else begin
            if (bus_rd) begin
                if (i >= 28)      exp_rd = 0;
                else if (i == 14) exp_rd = m_en;
                else if (i == 15) exp_rd = irq_status;
                else              exp_rd = m_regs[i];
            end
            exp_req = bus_wr && (i == 1) && !m_regs[1][2] && bus_wdata[2];
            if (bus_wr && i < 28 && i != 14 && i != 15) begin
                m_regs[i] = bus_wdata;
                if (i == 12) m_en = m_en | bus_wdata;
                if (i == 13) m_en = m_en & ~bus_wdata;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (bus_rdata !== exp_rd || reset_req !== exp_req) begin
                errors++;
                $display("FAIL %s: rdata=%h req=%b expected rdata=%h req=%b",
                         exp_tag, bus_rdata, reset_req, exp_rd, exp_req);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired: cycles=%0d expected under 100000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks + 1);
                $finish;
            end
        end
    end

    task automatic op(input string tag, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic r);
        @(negedge clk);
        cur_tag = tag; bus_wr = w; bus_addr = a; bus_wdata = d; bus_rd = r;
    endtask

    task automatic rd_all(input string tag);
        for (int k = 0; k < 28; k++) op(tag, 0, 8'(k * 4), 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset values, irq input nonzero for 0x3C
        irq_status = 32'h0000_A00F;
        rd_all("R1");
        // R2 plain storage and hold
        op("R2", 1, 8'h08, 32'hDEAD_BEEF, 0);
        op("R2", 1, 8'h40, 32'h1234_5678, 0);
        op("R2", 1, 8'h6C, 32'hFFFF_FFFF, 0);
        op("R2", 0, 8'h08, 0, 1);
        op("R2", 0, 8'h40, 0, 1);
        op("R2", 0, 8'h6C, 0, 0);
        op("R2", 0, 8'h00, 0, 0);
        op("R2", 0, 8'h6C, 0, 1);
        // R9 read and write same word same cycle
        op("R9", 1, 8'h44, 32'h0BAD_F00D, 1);
        op("R9", 0, 8'h44, 0, 1);
        // R3 set alias
        op("R3", 1, 8'h30, 32'h0000_00A5, 0);
        op("R3", 1, 8'h30, 32'h8000_0100, 1);
        op("R3", 0, 8'h38, 0, 1);
        op("R3", 0, 8'h30, 0, 1);
        // R4 clear alias
        op("R4", 1, 8'h34, 32'h8000_0005, 0);
        op("R4", 0, 8'h38, 0, 1);
        op("R4", 0, 8'h34, 0, 1);
        // R5 read-only words
        op("R5", 1, 8'h38, 32'hFFFF_FFFF, 0);
        op("R5", 1, 8'h3C, 32'h5555_5555, 0);
        op("R5", 0, 8'h38, 0, 1);
        irq_status = 32'h1357_9BDF;
        op("R5", 0, 8'h3C, 0, 1);
        irq_status = 32'h0000_0000;
        op("R5", 0, 8'h3C, 0, 1);
        // R6 out of range
        op("R6", 1, 8'h70, 32'hCAFE_CAFE, 0);
        op("R6", 1, 8'hFC, 32'h7777_7777, 0);
        op("R6", 0, 8'h70, 0, 1);
        op("R6", 0, 8'h00, 0, 1);
        op("R6", 0, 8'hFC, 0, 1);
        rd_all("R6");
        // R7 soft reset rise
        op("R7", 1, 8'h04, 32'h0000_1380, 0);
        op("R7", 0, 8'h04, 0, 1);
        op("R7", 1, 8'h04, 32'h0000_0004, 0);
        op("R7", 0, 8'h04, 0, 1);
        // R8 no request when bit stays set or stays clear
        op("R8", 1, 8'h04, 32'h0000_00FF, 0);
        op("R8", 0, 8'h00, 0, 0);
        op("R8", 1, 8'h04, 32'h0000_0000, 0);
        op("R8", 1, 8'h04, 32'h0000_0003, 0);
        op("R8", 1, 8'h04, 32'h0000_0004, 0);
        op("R8", 0, 8'h00, 0, 0);
        op("R8", 0, 8'h00, 0, 0);
        // R1 again after a second reset
        rst = 1;
        op("R1", 0, 8'h00, 0, 0);
        op("R1", 0, 8'h00, 0, 0);
        rst = 0;
        rd_all("R1");
        op("R1", 0, 8'h00, 0, 0);
        op("R1", 0, 8'h00, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule